// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block sits behind the write side of a parallel NOR flash bus and turns the stream of single-clock write strokes into device operations. Each stroke carries an address and a 16-bit data word. The block recognises multi-write command sequences, most of which begin with a two-write unlock prefix. It keeps track of the resting mode of the device: read array, autoselect, CFI query, unlock bypass, erase-suspend-read, or secured-region access. When a sequence completes, it issues a one-clock operation pulse. The pulse carries the operation kind and the latched address and data, which stay on the outputs until the next operation.

The block does not model the array, program and erase timing, or status reads. The embedded-operation engine reports through `busy` that a program or erase is running. While `busy` is high, only a suspend write is acted on. A sector erase that has been issued counts as running for as long as `busy` stays high.

The sequence states are:
- `SQ_IDLE`: resting in the current mode.
- `SQ_UL1` and `SQ_UL2`: first and second unlock write seen.
- `SQ_PGM`: a program is armed and waits for its address and data.
- `SQ_ER0`, `SQ_ER1` and `SQ_ER2`: erase setup seen, then the second unlock in two steps.
- `SQ_BYP_PGM`: a bypass program is armed.
- `SQ_BYP_EXIT`: the first write of the bypass exit has been seen.
- `SQ_SEC_EXIT`: the secured-region exit is armed.

The transitions are named `unlock`, `select`, `arm`, `issue`, `drop`, `reset`, `suspend` and `resume`.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), `op_valid` is 0 and `op_kind` is 0 (none).
- R2: A program takes four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, then the target address and data. After the clock edge of the fourth write, `op_valid` is high for exactly one cycle with `op_kind`=1. `op_addr` and `op_data` hold that address and data until the next operation.
- R3: Unlock followed by 90h at 555h enters autoselect (`mode`=1). A write of F0h at any address returns to read array (`mode`=0).
- R4: An erase takes six writes: unlock, 80h at 555h, unlock again, then a final write. A final 10h at 555h issues a chip erase (`op_kind`=2). A final 30h at any address issues a sector erase (`op_kind`=3); its `op_addr` is the write address with bits 14..0 cleared, so bits 21..15 name the sector. Erase setup is refused while an erase is suspended.
- R5: Unlock followed by 20h at 555h enters unlock bypass (`mode`=3). In that mode, A0h at any address followed by one address/data write issues a program. F0h has no effect. Only 90h followed by 00h, both at any address, returns to `mode`=0.
- R6: 30h in the final erase write only counts in `SQ_ER2`. Outside it, a single B0h suspends (`op_kind`=4, `mode`=4), and only while a sector erase runs with `busy` high. A single 30h resumes (`op_kind`=5, `mode`=0), and only from `mode`=4. While an erase is suspended, F0h returns to `mode`=4 instead of 0.
- R7: 98h at address 55h enters CFI query (`mode`=2), but only from read array or autoselect. F0h leaves CFI.
- R8: Unlock followed by 88h at 555h enters the secured region (`mode`=5). Unlock followed by 90h at 555h, then 00h at any address, returns to `mode`=0.
- R9: A write that does not fit the expected next step drops the partial sequence. No operation is issued and the mode is unchanged.
- R10: Unlock and command cycles compare only address bits 10..0 and data bits 7..0.
- R11: While `busy` is high, every write other than a valid suspend is ignored.
- R12: Cycles with `wr_en` low (bus reads) never advance the sequence or change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock write strobe |
| wr_addr | input | ADDR_W (22) | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Embedded operation running |
| op_valid | output | 1 | One-clock operation pulse |
| op_kind | output | 3 | 0 none, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W (22) | Address of the last operation |
| op_data | output | 16 | Data of the last operation |
| mode | output | 3 | 0 read, 1 autoselect, 2 CFI, 3 bypass, 4 erase-suspend-read, 5 secured |

## Verification
The hardest situation to reach is a suspended erase that is then left through autoselect. Getting there needs a full six-write sector erase, then `busy` raised by the bench in the cycle after the pulse, then a B0h write. After that come an unlock into autoselect and an F0h write, which must land back in erase-suspend-read rather than read array. The bench builds this chain in one directed task, checking the mode at every step. It also tries an erase setup and a stray B0h on either side of the resume to show they are refused.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_CFI     = 3'd2,
        MODE_BYPASS  = 3'd3,
        MODE_ESUSP   = 3'd4,
        MODE_SECURE  = 3'd5
    } mode_t;

    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_PROGRAM      = 3'd1,
        OP_CHIP_ERASE   = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_SUSPEND      = 3'd4,
        OP_RESUME       = 3'd5
    } op_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UL1,
        SQ_UL2,
        SQ_PGM,
        SQ_ER0,
        SQ_ER1,
        SQ_ER2,
        SQ_BYP_PGM,
        SQ_BYP_EXIT,
        SQ_SEC_EXIT
    } seq_t;

    // Address match flags for the three special command addresses
    typedef struct packed {
        logic at_055;
        logic at_2aa;
        logic at_555;
    } addr_hit_t;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_SECURE   = 8'h88;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_CFI      = 8'h98;
    localparam logic [7:0] CMD_ZERO     = 8'h00;

endpackage

// File: rtl/nor_cycle_match.sv
module nor_cycle_match
    import nor_cmd_pkg::*;
#(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] addr_lo,
    output addr_hit_t        hit
);

    localparam int NKEYS = 3;
    localparam logic [NKEYS-1:0][CMP_W-1:0] KEYS = {
        CMP_W'(12'h055),
        CMP_W'(12'h2AA),
        CMP_W'(12'h555)
    };

    logic [NKEYS-1:0] hit_v;

    for (genvar i = 0; i < NKEYS; i++) begin : g_key
        assign hit_v[i] = (addr_lo == KEYS[i]);
    end

    assign hit = addr_hit_t'(hit_v);

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  addr_hit_t         hit,
    input  logic              busy,
    output mode_t             mode,
    output logic              issue,
    output op_t               issue_kind,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [DATA_W-1:0] issue_data
);

    localparam logic [ADDR_W-1:0] SECT_MASK =
        ~((ADDR_W'(1) << SECT_LSB) - ADDR_W'(1));

    seq_t  seq, seq_n;
    mode_t mode_n;
    logic  susp, susp_n;      // an erase is suspended
    logic  run, run_n;        // a sector erase is running
    logic [7:0] cmd;

    assign cmd = wr_data[7:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq  <= SQ_IDLE;
            mode <= MODE_READ;
            susp <= 1'b0;
            run  <= 1'b0;
        end else begin
            seq  <= seq_n;
            mode <= mode_n;
            susp <= susp_n;
            run  <= run_n;
        end
    end

    // Next state and issue decision
    always_comb begin
        seq_n      = seq;
        mode_n     = mode;
        susp_n     = susp;
        run_n      = run && busy;
        issue      = 1'b0;
        issue_kind = OP_NONE;
        issue_addr = wr_addr;
        issue_data = wr_data;

        if (wr_en && busy) begin
            // suspend: only a B0h during a running sector erase
            if (cmd == CMD_SUSPEND && run) begin
                issue      = 1'b1;
                issue_kind = OP_SUSPEND;
                mode_n     = MODE_ESUSP;
                susp_n     = 1'b1;
                run_n      = 1'b0;
                seq_n      = SQ_IDLE;
            end
        end else if (wr_en) begin
            unique case (seq)
                SQ_IDLE: begin
                    unique case (mode)
                        MODE_BYPASS: begin
                            if (cmd == CMD_PROGRAM)       seq_n = SQ_BYP_PGM;
                            else if (cmd == CMD_AUTOSEL)  seq_n = SQ_BYP_EXIT;
                        end
                        MODE_CFI: begin
                            if (cmd == CMD_RESET)
                                mode_n = susp ? MODE_ESUSP : MODE_READ;
                        end
                        default: begin
                            if (cmd == CMD_RESET && mode != MODE_SECURE) begin
                                mode_n = susp ? MODE_ESUSP : MODE_READ;
                            end else if (cmd == CMD_UNLOCK_A && hit.at_555) begin
                                seq_n = SQ_UL1;
                            end else if (cmd == CMD_CFI && hit.at_055 &&
                                         (mode == MODE_READ || mode == MODE_AUTOSEL)) begin
                                mode_n = MODE_CFI;
                            end else if (cmd == CMD_SECTOR && mode == MODE_ESUSP) begin
                                issue      = 1'b1;
                                issue_kind = OP_RESUME;
                                mode_n     = MODE_READ;
                                susp_n     = 1'b0;
                                run_n      = 1'b1;
                            end
                        end
                    endcase
                end
                SQ_UL1: seq_n = (cmd == CMD_UNLOCK_B && hit.at_2aa) ? SQ_UL2 : SQ_IDLE;
                SQ_UL2: begin
                    seq_n = SQ_IDLE;
                    if (hit.at_555) begin
                        unique case (cmd)
                            CMD_AUTOSEL: begin
                                if (mode == MODE_SECURE) seq_n = SQ_SEC_EXIT;
                                else                     mode_n = MODE_AUTOSEL;
                            end
                            CMD_PROGRAM: seq_n = SQ_PGM;
                            CMD_BYPASS:  if (mode == MODE_READ) mode_n = MODE_BYPASS;
                            CMD_SECURE:  if (mode == MODE_READ) mode_n = MODE_SECURE;
                            CMD_ERASE:   if (!susp) seq_n = SQ_ER0;
                            default:     seq_n = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PGM, SQ_BYP_PGM: begin
                    issue      = 1'b1;
                    issue_kind = OP_PROGRAM;
                    seq_n      = SQ_IDLE;
                end
                SQ_ER0: seq_n = (cmd == CMD_UNLOCK_A && hit.at_555) ? SQ_ER1 : SQ_IDLE;
                SQ_ER1: seq_n = (cmd == CMD_UNLOCK_B && hit.at_2aa) ? SQ_ER2 : SQ_IDLE;
                SQ_ER2: begin
                    seq_n = SQ_IDLE;
                    if (cmd == CMD_CHIP && hit.at_555) begin
                        issue      = 1'b1;
                        issue_kind = OP_CHIP_ERASE;
                    end else if (cmd == CMD_SECTOR) begin
                        issue      = 1'b1;
                        issue_kind = OP_SECTOR_ERASE;
                        issue_addr = wr_addr & SECT_MASK;
                        run_n      = 1'b1;
                    end
                end
                SQ_BYP_EXIT: begin
                    seq_n = SQ_IDLE;
                    if (cmd == CMD_ZERO) mode_n = MODE_READ;
                end
                SQ_SEC_EXIT: begin
                    seq_n = SQ_IDLE;
                    if (cmd == CMD_ZERO) mode_n = MODE_READ;
                end
                default: seq_n = SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_op_latch.sv
module nor_op_latch
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  op_t               issue_kind,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] issue_data,
    output logic              op_valid,
    output op_t               op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= issue;
            if (issue) begin
                op_kind <= issue_kind;
                op_addr <= issue_addr;
                op_data <= issue_data;
            end
        end
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int CMP_W    = 11,
    parameter int SECT_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [2:0]        mode
);

    addr_hit_t         hit;
    mode_t             mode_q;
    logic              issue;
    op_t               issue_kind;
    logic [ADDR_W-1:0] issue_addr;
    logic [DATA_W-1:0] issue_data;
    op_t               kind_q;

    nor_cycle_match #(.CMP_W(CMP_W)) u_match (
        .addr_lo (wr_addr[CMP_W-1:0]),
        .hit     (hit)
    );

    nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hit        (hit),
        .busy       (busy),
        .mode       (mode_q),
        .issue      (issue),
        .issue_kind (issue_kind),
        .issue_addr (issue_addr),
        .issue_data (issue_data)
    );

    nor_op_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_kind (issue_kind),
        .issue_addr (issue_addr),
        .issue_data (issue_data),
        .op_valid   (op_valid),
        .op_kind    (kind_q),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    assign op_kind = kind_q;
    assign mode    = mode_q;

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] op_data,
    input logic [2:0]        mode
);

    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << SECT_LSB) - ADDR_W'(1);

    // R2: an operation only follows a write
    a_r2_op_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));

    // R2: outputs hold between operations
    a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> ($stable(op_addr) && $stable(op_data) && $stable(op_kind)));

    // R4: sector erase address is sector aligned
    a_r4_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd3) |-> ((op_addr & LOW_MASK) == '0));

    // R5: no erase is issued out of bypass mode
    a_r5_no_erase_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_kind == 3'd2 || op_kind == 3'd3)) |-> ($past(mode) != 3'd3));

    // R6: suspend lands in erase-suspend-read
    a_r6_suspend_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd4) |-> (mode == 3'd4));

    // R6: resume only from erase-suspend-read
    a_r6_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd5) |-> ($past(mode) == 3'd4));

    // R11: busy blocks everything but suspend
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_data[7:0] != 8'hB0) |=> (!op_valid && $stable(mode)));

    // R12: bus reads leave the mode alone
    a_r12_idle_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode));

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .busy     (busy),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .mode     (mode)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          busy = 1'b0;
    logic          op_valid;
    logic [2:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [2:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nor_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write stroke; returns at the negedge after the capturing edge
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 op_valid", op_valid, 0);
        chk("R1 op_kind", op_kind, 0);
    endtask

    task automatic t_program();
        unlock();
        wr(22'h555, 16'h00A0);
        chk("R2 no early op", op_valid, 0);
        wr(22'h012345, 16'hBEEF);
        chk("R2 valid", op_valid, 1);
        chk("R2 kind", op_kind, 1);
        chk("R2 addr", op_addr, 32'h012345);
        chk("R2 data", op_data, 16'hBEEF);
        @(negedge clk);
        chk("R2 one cycle", op_valid, 0);
        chk("R2 addr held", op_addr, 32'h012345);
    endtask

    task automatic t_mismatch();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0056);
        wr(22'h555, 16'h00A0);
        wr(22'h000100, 16'h1111);
        chk("R9 no op", op_valid, 0);
        chk("R9 addr kept", op_addr, 32'h012345);
        chk("R9 mode", mode, 0);
    endtask

    task automatic t_compare();
        wr(22'h3FF555, 16'h12AA);
        wr(22'h1522AA, 16'hFF55);
        wr(22'h00D555, 16'h33A0);
        wr(22'h002000, 16'h0042);
        chk("R10 valid", op_valid, 1);
        chk("R10 addr", op_addr, 32'h002000);
        chk("R10 data", op_data, 16'h0042);
    endtask

    task automatic t_autosel_cfi();
        unlock();
        wr(22'h555, 16'h0090);
        chk("R3 autoselect", mode, 1);
        wr(22'h000777, 16'h00F0);
        chk("R3 reset", mode, 0);
        wr(22'h000055, 16'h0098);
        chk("R7 cfi from read", mode, 2);
        wr(22'h000000, 16'h00F0);
        chk("R7 cfi exit", mode, 0);
        unlock();
        wr(22'h555, 16'h0090);
        wr(22'h000055, 16'h0098);
        chk("R7 cfi from autoselect", mode, 2);
        wr(22'h000000, 16'h00F0);
        chk("R7 back to read", mode, 0);
    endtask

    task automatic t_bypass();
        unlock();
        wr(22'h555, 16'h0020);
        chk("R5 bypass entry", mode, 3);
        wr(22'h000999, 16'h00A0);
        wr(22'h004444, 16'h5A5A);
        chk("R5 bypass program", op_valid, 1);
        chk("R5 bypass kind", op_kind, 1);
        chk("R5 bypass addr", op_addr, 32'h004444);
        wr(22'h000000, 16'h00F0);
        chk("R5 F0 ignored", mode, 3);
        wr(22'h000055, 16'h0098);
        chk("R7 cfi refused in bypass", mode, 3);
        wr(22'h000123, 16'h0090);
        wr(22'h000321, 16'h0000);
        chk("R5 bypass exit", mode, 0);
    endtask

    task automatic t_erase_suspend();
        unlock(); wr(22'h555, 16'h0080);
        unlock(); wr(22'h555, 16'h0010);
        chk("R4 chip erase", op_kind, 2);
        chk("R4 chip valid", op_valid, 1);
        unlock(); wr(22'h555, 16'h0080);
        unlock(); wr(22'h2B1234, 16'h0030);
        chk("R4 sector erase", op_kind, 3);
        chk("R4 sector addr", op_addr, 32'h2B0000);
        busy = 1'b1;
        unlock(); wr(22'h555, 16'h0090);
        chk("R11 busy ignores", mode, 0);
        wr(22'h000000, 16'h00B0);
        chk("R6 suspend op", op_kind, 4);
        chk("R6 suspend valid", op_valid, 1);
        chk("R6 suspend mode", mode, 4);
        busy = 1'b0;
        unlock(); wr(22'h555, 16'h0090);
        chk("R6 autoselect from suspend", mode, 1);
        wr(22'h000000, 16'h00F0);
        chk("R6 F0 back to suspend", mode, 4);
        unlock(); wr(22'h555, 16'h0080);
        unlock(); wr(22'h555, 16'h0010);
        chk("R4 erase refused in suspend", op_valid, 0);
        wr(22'h000000, 16'h0030);
        chk("R6 resume op", op_kind, 5);
        chk("R6 resume mode", mode, 0);
        @(negedge clk);
        @(negedge clk);
        wr(22'h000000, 16'h00B0);
        chk("R6 B0 not busy", op_valid, 0);
        busy = 1'b1;
        wr(22'h000000, 16'h00B0);
        chk("R6 B0 no erase", op_valid, 0);
        chk("R6 mode kept", mode, 0);
        busy = 1'b0;
        @(negedge clk);
        wr(22'h000000, 16'h0030);
        chk("R6 30 refused in read", op_valid, 0);
    endtask

    task automatic t_secure();
        unlock();
        wr(22'h555, 16'h0088);
        chk("R8 secure entry", mode, 5);
        unlock();
        wr(22'h555, 16'h0090);
        chk("R8 still secure", mode, 5);
        wr(22'h000000, 16'h0000);
        chk("R8 secure exit", mode, 0);
    endtask

    task automatic t_reads();
        wr_addr = 22'h555; wr_data = 16'h00AA;
        repeat (3) @(negedge clk);
        wr(22'h2AA, 16'h0055);
        wr(22'h555, 16'h0090);
        chk("R12 reads do not unlock", mode, 0);
        unlock();
        wr_addr = 22'h555; wr_data = 16'h0090;
        repeat (3) @(negedge clk);
        chk("R12 read keeps mode", mode, 0);
        wr(22'h555, 16'h0090);
        chk("R12 sequence kept over reads", mode, 1);
        wr(22'h000000, 16'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_mismatch();
        t_compare();
        t_autosel_cfi();
        t_bypass();
        t_erase_suspend();
        t_secure();
        t_reads();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule